// File: doc/BRIEF.md
# Link Request Serial Decoder

This block sits on the physical-layer side of a one-bit request line driven by a link controller. It samples the line on the system clock and rebuilds each serial request frame. It emits a one-cycle valid strobe carrying the request kind, a normalized speed, a null-packet flag, and the address and data fields of register accesses. The line idles low, and every frame opens with a 1 start bit.

Bus requests come in two lengths. The short legacy form carries a two-bit speed code. The extended form carries a three-bit speed code. No mode pin selects between them. The decoder looks at the bit that follows the seventh. A 1 there starts a new frame, so the request just received was a short one. A 0 there is the stop bit of an extended one. The two speed encodings are chosen so that the legacy stop bit falls where the extended least-significant speed bit sits, so S100, S200 and S400 give the same result in either form. An extended speed code above S400 is accepted and flagged for a null-packet transmission.

Two configuration enables, taken from configuration register 5, gate two arbitration features:
- Accelerated asynchronous arbitration. The link arms or disarms it with its own control frame, and it is reported only when the enable is set.
- Concatenation of a packet at a different speed from the previous one. It is granted only when the other enable is set.

Top module: `lreq_decoder`

## Requirements
- R1: A frame begins with a 1 on `lreq_i` after idle, followed by a 3-bit kind field sent MSB first. Kinds 0 to 4 are bus requests: 0 immediate, 1 isochronous, 2 priority, 3 fair, 4 concatenation. Kind 5 is a register read, 6 a register write, 7 an acceleration control.
- R2: A bus request's speed code follows the kind field MSB first. Legacy codes 00, 01 and 10 and extended codes 000, 010 and 100 yield `req_speed_o` 0, 1 and 2 (S100, S200, S400), with `req_null_o` low.
- R3: If the bit after the seventh frame bit is 1, the frame is a legacy request with a 2-bit code. That bit is also the start bit of the next frame, and both requests are output separately.
- R4: An extended code of 101, 110 or 111, and a legacy code of 11, sets `req_null_o` with `req_speed_o` = 2. Extended codes 001 and 011 ignore their low bit and yield 0 and 1.
- R5: `req_accel_o` is high with a bus request only when `cfg_accel_en_i` is 1 and the latest acceleration control frame carried a payload bit of 1. After reset the feature is disarmed.
- R6: `req_concat_o` is high only with a kind-4 request. It is high when `cfg_mspeed_en_i` is 1, or when the request has the same non-null speed as the previous bus request. With neither condition it stays low.
- R7: Non-bus frames have fixed lengths and are never split by the legacy rule:
  - register read: 4-bit address, then a stop bit;
  - register write: 4-bit address, 8-bit data, then a stop bit;
  - acceleration control: 1 payload bit, then a stop bit.

  These frames report `req_speed_o` = 0 and `req_null_o` = 0.
- R8: `req_valid_o` is high for exactly one cycle per request. It rises in the cycle after the clock edge that samples the frame's deciding bit: the stop bit of a non-bus or extended frame, or the following start bit of a legacy frame.
- R9: A synchronous reset returns the decoder to idle and drops any partly received frame. It also clears the acceleration arm state and the previous-speed memory.
- R10: An extended request whose stop bit is followed at once by a new start bit yields both requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| lreq_i | input | 1 | Serial request line from the link |
| cfg_accel_en_i | input | 1 | Enable for accelerated asynchronous arbitration |
| cfg_mspeed_en_i | input | 1 | Enable for concatenation across speeds |
| req_valid_o | output | 1 | One-cycle strobe for a decoded request |
| req_kind_o | output | 3 | Request kind code |
| req_speed_o | output | 2 | Normalized speed: 0 S100, 1 S200, 2 S400 |
| req_null_o | output | 1 | Transmit a null packet for this request |
| req_addr_o | output | ADDR_W | Register address for read and write |
| req_data_o | output | DATA_W | Register write data |
| req_accel_o | output | 1 | Accelerated arbitration allowed for this request |
| req_concat_o | output | 1 | Concatenation granted for this request |

## Verification
The hardest case is a short request whose stop bit is followed at once by a new start bit. In that case the frame boundary exists only in the decoder's own interpretation. A legacy request that is followed by idle looks exactly like an extended one. The stimulus therefore concatenates bit strings with no idle gap: a legacy request followed directly by a register read or by another legacy request, and an extended request followed directly by a register write whose address is all ones. The ones-filled payload checks that register frames are not split by the legacy rule.

// File: rtl/lreq_pkg.sv
package lreq_pkg;

    localparam int KIND_W = 3;
    localparam int LSPD_W = 2;
    localparam int XSPD_W = 3;

    typedef enum logic [KIND_W-1:0] {
        RQ_IMM  = 3'd0,
        RQ_ISO  = 3'd1,
        RQ_PRI  = 3'd2,
        RQ_FAIR = 3'd3,
        RQ_CAT  = 3'd4,
        RQ_RD   = 3'd5,
        RQ_WR   = 3'd6,
        RQ_ACC  = 3'd7
    } rq_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KIND,
        ST_BODY,
        ST_DECIDE,
        ST_STOP
    } fsm_e;

    function automatic logic is_bus(input logic [KIND_W-1:0] k);
        return k <= 3'(RQ_CAT);
    endfunction

endpackage

// File: rtl/lreq_frame_fsm.sv
module lreq_frame_fsm
    import lreq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                lreq_i,
    output logic                frm_valid_o,
    output logic [KIND_W-1:0]   frm_kind_o,
    output logic [XSPD_W-1:0]   frm_code_o,
    output logic [ADDR_W-1:0]   frm_addr_o,
    output logic [DATA_W-1:0]   frm_data_o,
    output logic                frm_flag_o
);

    localparam int PAY_W = ADDR_W + DATA_W;
    localparam int CNT_W = $clog2(PAY_W + 1);

    typedef struct packed {
        fsm_e              st;
        logic [CNT_W-1:0]  cnt;
        logic [KIND_W-1:0] kind;
        logic [PAY_W-1:0]  body;
        logic              valid;
        logic [KIND_W-1:0] okind;
        logic [XSPD_W-1:0] code;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              flag;
    } fsm_s;

    localparam fsm_s FSM_RST = '{st: ST_IDLE, default: '0};

    fsm_s fsm_q, fsm_d;

    function automatic logic [CNT_W-1:0] body_len(input logic [KIND_W-1:0] k);
        case (k)
            RQ_RD:   return CNT_W'(ADDR_W);
            RQ_WR:   return CNT_W'(PAY_W);
            RQ_ACC:  return CNT_W'(1);
            default: return CNT_W'(XSPD_W);
        endcase
    endfunction

    always_comb begin
        fsm_d       = fsm_q;
        fsm_d.valid = 1'b0;
        case (fsm_q.st)
            ST_IDLE: begin
                if (lreq_i) begin
                    fsm_d.st  = ST_KIND;
                    fsm_d.cnt = '0;
                end
            end
            ST_KIND: begin
                fsm_d.kind = {fsm_q.kind[KIND_W-2:0], lreq_i};
                if (fsm_q.cnt == CNT_W'(KIND_W - 1)) begin
                    fsm_d.st   = ST_BODY;
                    fsm_d.cnt  = '0;
                    fsm_d.body = '0;
                end else begin
                    fsm_d.cnt = fsm_q.cnt + 1'b1;
                end
            end
            ST_BODY: begin
                fsm_d.body = {fsm_q.body[PAY_W-2:0], lreq_i};
                if (fsm_q.cnt == body_len(fsm_q.kind) - 1'b1) begin
                    fsm_d.st = is_bus(fsm_q.kind) ? ST_DECIDE : ST_STOP;
                end else begin
                    fsm_d.cnt = fsm_q.cnt + 1'b1;
                end
            end
            ST_DECIDE: begin
                fsm_d.valid = 1'b1;
                fsm_d.okind = fsm_q.kind;
                fsm_d.addr  = '0;
                fsm_d.data  = '0;
                fsm_d.flag  = 1'b0;
                if (lreq_i) begin
                    // short frame: this bit opens the next request
                    fsm_d.code = {fsm_q.body[XSPD_W-1 -: LSPD_W], 1'b0};
                    fsm_d.st   = ST_KIND;
                    fsm_d.cnt  = '0;
                end else begin
                    fsm_d.code = fsm_q.body[XSPD_W-1:0];
                    fsm_d.st   = ST_IDLE;
                end
            end
            ST_STOP: begin
                fsm_d.valid = 1'b1;
                fsm_d.okind = fsm_q.kind;
                fsm_d.code  = '0;
                fsm_d.flag  = fsm_q.body[0];
                fsm_d.addr  = '0;
                fsm_d.data  = '0;
                if (fsm_q.kind == RQ_RD) begin
                    fsm_d.addr = fsm_q.body[ADDR_W-1:0];
                end else if (fsm_q.kind == RQ_WR) begin
                    fsm_d.addr = fsm_q.body[PAY_W-1:DATA_W];
                    fsm_d.data = fsm_q.body[DATA_W-1:0];
                end
                fsm_d.st = ST_IDLE;
            end
            default: fsm_d = FSM_RST;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) fsm_q <= FSM_RST;
        else       fsm_q <= fsm_d;
    end

    assign frm_valid_o = fsm_q.valid;
    assign frm_kind_o  = fsm_q.okind;
    assign frm_code_o  = fsm_q.code;
    assign frm_addr_o  = fsm_q.addr;
    assign frm_data_o  = fsm_q.data;
    assign frm_flag_o  = fsm_q.flag;

    AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        fsm_q.valid |=> !fsm_q.valid) else $error("strobe longer than one cycle"); // R8

    AST_RESET_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (fsm_q.st == ST_IDLE && !fsm_q.valid)) else $error("not idle after reset"); // R9

    AST_DECIDE_AFTER_BODY: assert property (@(posedge clk_i) disable iff (rst_i)
        (fsm_q.st == ST_DECIDE) |-> $past(fsm_q.st) == ST_BODY) else $error("decide without body"); // R3

endmodule

// File: rtl/lreq_speed_map.sv
module lreq_speed_map #(
    parameter int CODE_W = 3
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [1:0]        speed_o,
    output logic              null_o
);

    localparam logic [CODE_W-1:0] TOP_CODE = CODE_W'(1) << (CODE_W - 1);

    always_comb begin
        null_o  = code_i > TOP_CODE;
        speed_o = null_o ? 2'd2 : code_i[CODE_W-1 -: 2];
    end

endmodule

// File: rtl/lreq_arb_policy.sv
module lreq_arb_policy
    import lreq_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              frm_valid_i,
    input  logic [KIND_W-1:0] frm_kind_i,
    input  logic [1:0]        speed_i,
    input  logic              null_i,
    input  logic              flag_i,
    input  logic              cfg_accel_en_i,
    input  logic              cfg_mspeed_en_i,
    output logic              accel_o,
    output logic              concat_o
);

    typedef struct packed {
        logic       armed;
        logic       have_last;
        logic       last_null;
        logic [1:0] last_spd;
    } pol_s;

    pol_s pol_q, pol_d;
    logic bus, same_spd;

    always_comb begin
        bus      = is_bus(frm_kind_i);
        same_spd = pol_q.have_last && !pol_q.last_null && !null_i
                   && (speed_i == pol_q.last_spd);
        accel_o  = frm_valid_i && bus && cfg_accel_en_i && pol_q.armed;
        concat_o = frm_valid_i && (frm_kind_i == RQ_CAT)
                   && (cfg_mspeed_en_i || same_spd);

        pol_d = pol_q;
        if (frm_valid_i && frm_kind_i == RQ_ACC) begin
            pol_d.armed = flag_i;
        end
        if (frm_valid_i && bus) begin
            pol_d.have_last = 1'b1;
            pol_d.last_null = null_i;
            pol_d.last_spd  = speed_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) pol_q <= '0;
        else       pol_q <= pol_d;
    end

    AST_CONCAT_SPEED_MATCH: assert property (@(posedge clk_i) disable iff (rst_i)
        (concat_o && !cfg_mspeed_en_i) |-> (speed_i == pol_q.last_spd)) else $error("concat speed"); // R6

    AST_ARM_CLEARED: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> !pol_q.armed) else $error("arm survives reset"); // R9

endmodule

// File: rtl/lreq_decoder.sv
module lreq_decoder
    import lreq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              lreq_i,
    input  logic              cfg_accel_en_i,
    input  logic              cfg_mspeed_en_i,
    output logic              req_valid_o,
    output logic [2:0]        req_kind_o,
    output logic [1:0]        req_speed_o,
    output logic              req_null_o,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic [DATA_W-1:0] req_data_o,
    output logic              req_accel_o,
    output logic              req_concat_o
);

    logic              frm_valid;
    logic [KIND_W-1:0] frm_kind;
    logic [XSPD_W-1:0] frm_code;
    logic              frm_flag;
    logic [1:0]        spd;
    logic              nul;

    lreq_frame_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) fsm_i (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .lreq_i      (lreq_i),
        .frm_valid_o (frm_valid),
        .frm_kind_o  (frm_kind),
        .frm_code_o  (frm_code),
        .frm_addr_o  (req_addr_o),
        .frm_data_o  (req_data_o),
        .frm_flag_o  (frm_flag)
    );

    lreq_speed_map #(
        .CODE_W (XSPD_W)
    ) map_i (
        .code_i  (frm_code),
        .speed_o (spd),
        .null_o  (nul)
    );

    lreq_arb_policy pol_i (
        .clk_i           (clk_i),
        .rst_i           (rst_i),
        .frm_valid_i     (frm_valid),
        .frm_kind_i      (frm_kind),
        .speed_i         (spd),
        .null_i          (nul),
        .flag_i          (frm_flag),
        .cfg_accel_en_i  (cfg_accel_en_i),
        .cfg_mspeed_en_i (cfg_mspeed_en_i),
        .accel_o         (req_accel_o),
        .concat_o        (req_concat_o)
    );

    assign req_valid_o = frm_valid;
    assign req_kind_o  = frm_kind;
    assign req_speed_o = spd;
    assign req_null_o  = frm_valid && nul;

    AST_NULL_BUS_ONLY: assert property (@(posedge clk_i) disable iff (rst_i)
        req_null_o |-> (req_valid_o && req_kind_o <= 3'd4)) else $error("null on non-bus"); // R4

    AST_REG_NO_SPEED: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_valid_o && req_kind_o > 3'd4) |-> (req_speed_o == 2'd0 && !req_null_o)) else $error("speed on register frame"); // R7

    AST_ACCEL_NEEDS_CFG: assert property (@(posedge clk_i) disable iff (rst_i)
        req_accel_o |-> cfg_accel_en_i) else $error("accel without enable"); // R5

    AST_CONCAT_ONLY_CAT: assert property (@(posedge clk_i) disable iff (rst_i)
        req_concat_o |-> (req_valid_o && req_kind_o == 3'd4)) else $error("concat on other kind"); // R6

endmodule

// File: tb/lreq_decoder_tb_top.sv
module lreq_decoder_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       lreq = 1'b0;
    logic       cfg_acc = 1'b0;
    logic       cfg_ms = 1'b0;
    logic       v;
    logic [2:0] kind;
    logic [1:0] spd;
    logic       nul;
    logic [3:0] addr;
    logic [7:0] data;
    logic       acc;
    logic       cat;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int n_rec = 0;
    int run_err = 0;
    logic prev_v = 1'b0;

    int r_kind[16], r_spd[16], r_nul[16], r_addr[16], r_data[16], r_acc[16], r_cat[16], r_cyc[16];

    always #4 clk = ~clk;

    lreq_decoder dut_i (
        .clk_i           (clk),
        .rst_i           (rst),
        .lreq_i          (lreq),
        .cfg_accel_en_i  (cfg_acc),
        .cfg_mspeed_en_i (cfg_ms),
        .req_valid_o     (v),
        .req_kind_o      (kind),
        .req_speed_o     (spd),
        .req_null_o      (nul),
        .req_addr_o      (addr),
        .req_data_o      (data),
        .req_accel_o     (acc),
        .req_concat_o    (cat)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (v && prev_v) run_err = run_err + 1;
        prev_v = v;
        if (v && n_rec < 16) begin
            r_kind[n_rec] = int'(kind);
            r_spd[n_rec]  = int'(spd);
            r_nul[n_rec]  = int'(nul);
            r_addr[n_rec] = int'(addr);
            r_data[n_rec] = int'(data);
            r_acc[n_rec]  = int'(acc);
            r_cat[n_rec]  = int'(cat);
            r_cyc[n_rec]  = cyc;
            n_rec = n_rec + 1;
        end
    end

    task automatic chk(input string rq, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            lreq = bits[i];
            @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        lreq = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic clr();
        n_rec = 0;
    endtask

    task automatic do_reset();
        lreq = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [31:0] f_leg(input int k, input int s);
        return 32'({1'b1, 3'(k), 2'(s), 1'b0});
    endfunction
    function automatic logic [31:0] f_ext(input int k, input int s);
        return 32'({1'b1, 3'(k), 3'(s), 1'b0});
    endfunction
    function automatic logic [31:0] f_rd(input int a);
        return 32'({1'b1, 3'd5, 4'(a), 1'b0});
    endfunction
    function automatic logic [31:0] f_wr(input int a, input int d);
        return 32'({1'b1, 3'd6, 4'(a), 8'(d), 1'b0});
    endfunction
    function automatic logic [31:0] f_acc(input int b);
        return 32'({1'b1, 3'd7, 1'(b), 1'b0});
    endfunction

    task automatic exp_rec(input int i, input string rq, input int k, input int s, input int nl);
        if (n_rec <= i) begin
            chk({rq, " record count"}, n_rec, i + 1);
        end else begin
            chk({rq, " kind"}, r_kind[i], k);
            chk({rq, " speed"}, r_spd[i], s);
            chk({rq, " null"}, r_nul[i], nl);
        end
    endtask

    task automatic t_reset_state();
        chk("R9 valid after reset", int'(v), 0);
        chk("R9 accel after reset", int'(acc), 0);
    endtask

    task automatic t_legacy_speeds();
        for (int s = 0; s < 3; s++) begin
            clr();
            send(f_leg(3, s), 7);
            idle(4);
            chk("R2 legacy count", n_rec, 1);
            exp_rec(0, "R2 legacy", 3, s, 0);
        end
    endtask

    task automatic t_ext_speeds();
        for (int s = 0; s < 8; s++) begin
            clr();
            send(f_ext(1, s), 8);
            idle(3);
            chk("R1 R4 ext count", n_rec, 1);
            if (s > 4) exp_rec(0, "R4 null", 1, 2, 1);
            else if (s[0]) exp_rec(0, "R4 low bit", 1, s >> 1, 0);
            else exp_rec(0, "R2 ext", 1, s >> 1, 0);
        end
    endtask

    task automatic t_latency();
        int end_cyc;
        clr();
        send(f_ext(0, 4), 8);
        end_cyc = cyc;
        idle(4);
        chk("R8 strobe count", n_rec, 1);
        if (n_rec > 0) chk("R8 strobe cycle", r_cyc[0], end_cyc);
    endtask

    task automatic t_b2b_legacy();
        clr();
        send(f_leg(2, 1), 7);
        send(f_rd(5), 9);
        idle(4);
        chk("R3 b2b count", n_rec, 2);
        exp_rec(0, "R3 legacy first", 2, 1, 0);
        exp_rec(1, "R3 read second", 5, 0, 0);
        if (n_rec > 1) chk("R3 read addr", r_addr[1], 5);
        clr();
        send(f_leg(3, 3), 7);
        send(f_leg(0, 2), 7);
        idle(4);
        chk("R3 two legacy count", n_rec, 2);
        exp_rec(0, "R4 legacy 11 null", 3, 2, 1);
        exp_rec(1, "R3 second legacy", 0, 2, 0);
    endtask

    task automatic t_b2b_ext();
        clr();
        send(f_ext(0, 4), 8);
        send(f_wr(15, 8'hA5), 17);
        idle(4);
        chk("R10 b2b count", n_rec, 2);
        exp_rec(0, "R10 ext first", 0, 2, 0);
        exp_rec(1, "R10 write second", 6, 0, 0);
        if (n_rec > 1) begin
            chk("R7 write addr", r_addr[1], 15);
            chk("R7 write data", r_data[1], 8'hA5);
        end
    endtask

    task automatic t_regs();
        clr();
        send(f_rd(12), 9);
        idle(2);
        send(f_wr(3, 8'hFF), 17);
        idle(2);
        send(f_acc(0), 6);
        idle(3);
        chk("R7 reg count", n_rec, 3);
        exp_rec(0, "R7 read", 5, 0, 0);
        exp_rec(1, "R7 write", 6, 0, 0);
        exp_rec(2, "R7 accel ctl", 7, 0, 0);
        if (n_rec > 1) begin
            chk("R7 read addr", r_addr[0], 12);
            chk("R7 write addr", r_addr[1], 3);
            chk("R7 write data", r_data[1], 8'hFF);
        end
    endtask

    task automatic t_accel();
        clr();
        cfg_acc = 1'b0;
        send(f_acc(1), 6);
        idle(2);
        send(f_ext(3, 0), 8);
        idle(2);
        cfg_acc = 1'b1;
        idle(1);
        send(f_ext(3, 0), 8);
        idle(2);
        send(f_acc(0), 6);
        idle(2);
        send(f_ext(3, 0), 8);
        idle(3);
        chk("R5 accel count", n_rec, 5);
        if (n_rec == 5) begin
            chk("R5 cfg off", r_acc[1], 0);
            chk("R5 armed and on", r_acc[2], 1);
            chk("R5 disarmed", r_acc[4], 0);
        end
    endtask

    task automatic t_concat();
        do_reset();
        clr();
        cfg_ms = 1'b0;
        send(f_ext(4, 2), 8);
        idle(2);
        send(f_ext(3, 2), 8);
        idle(2);
        send(f_ext(4, 2), 8);
        idle(2);
        send(f_ext(4, 4), 8);
        idle(2);
        cfg_ms = 1'b1;
        idle(1);
        send(f_ext(4, 0), 8);
        idle(2);
        send(f_ext(3, 0), 8);
        idle(3);
        cfg_ms = 1'b0;
        chk("R6 concat count", n_rec, 6);
        if (n_rec == 6) begin
            chk("R6 no previous speed", r_cat[0], 0);
            chk("R6 same speed", r_cat[2], 1);
            chk("R6 diff speed disabled", r_cat[3], 0);
            chk("R6 diff speed enabled", r_cat[4], 1);
            chk("R6 non-concat kind", r_cat[5], 0);
        end
    endtask

    task automatic t_reset_partial();
        cfg_acc = 1'b1;
        send(f_acc(1), 6);
        idle(2);
        clr();
        send(32'b11011, 5);
        do_reset();
        send(f_ext(1, 2), 8);
        idle(3);
        chk("R9 partial dropped count", n_rec, 1);
        exp_rec(0, "R9 after reset", 1, 1, 0);
        if (n_rec > 0) chk("R9 accel disarmed", r_acc[0], 0);
        cfg_acc = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL R8 watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_legacy_speeds();
        t_ext_speeds();
        t_latency();
        t_b2b_legacy();
        t_b2b_ext();
        t_regs();
        t_accel();
        t_concat();
        t_reset_partial();
        chk("R8 strobe width", run_err, 0);
        finish_run();
    end

endmodule